// File: doc/BRIEF.md
# Clocked Serial Byte Shifter

This block moves one byte at a time over a synchronous serial link. A host writes a byte into the data register, then sets the start field of the mode register. The block then drives the byte out on the serial data pin, one bit per shift clock. In the same transfer it shifts the bits arriving on the serial input into that same register. When the eighth bit has been taken in, the register holds the received byte and a completion flag is raised. Each transfer is one-shot: software reloads the data register and sets start again for the next byte.

The shift clock comes from one of two sources. It is either produced locally by dividing the system clock, in which case it is driven out on the clock pin, or it is taken from the clock pin. A two-bit field in the mode register chooses the source. The bit order and the output enables for the clock pin and the data pin are also fields of the mode register. If the interrupt enable is set, the completion flag drives an interrupt request.

Top module: `ser_shift_port`

## Requirements
- R1: After reset, the mode register reads 0x00 and the data register reads 0x00. `sck_o` and `sd_o` are 1 and `irq_o` is 0.
- R2: Mode register fields by bit are: 7 completion flag, 6 interrupt enable, 5 clock pin drive enable, 4 data pin drive enable, 3:2 clock source code, 1 bit order, 0 start. A write with start and flag at 0 reads back exactly as written.
- R3: `sd_o` changes only in the cycle in which a shift clock falling edge is acted upon. `sd_i` is sampled on the rising edge.
- R4: Clock source codes 00, 01 and 10 select internal shift clocks with half periods of 1, 4 and 16 system clocks. `sck_o` idles high. The first falling edge comes one half period after the start write, and the flag rises 16 half periods after it.
- R5: Code 11 selects the clock on `sck_i`, taken through a two-flop synchronizer. It must run at most one quarter of the system clock rate. `sck_o` stays high in this mode.
- R6: Bit order 0 sends and receives the most significant bit first. Bit order 1 sends and receives the least significant bit first.
- R7: After the eighth rising edge, the data register holds the 8 received bits. In the same cycle the start bit clears and the completion flag sets.
- R8: `irq_o` equals completion flag AND interrupt enable. Writing 0 to bit 7 clears the flag. Writing 1 to bit 7 leaves it unchanged.
- R9: A write to the data register while start is set is ignored. A write while idle loads it.
- R10: While start is set, writes to the clock source, bit order and start fields are ignored.
- R11: `sck_oe_o` follows mode bit 5 and `sd_oe_o` follows mode bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 mode, 1 data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register |
| sck_i | input | 1 | External shift clock |
| sck_o | output | 1 | Internal shift clock out |
| sck_oe_o | output | 1 | Clock pin drive enable |
| sd_i | input | 1 | Serial data in |
| sd_o | output | 1 | Serial data out |
| sd_oe_o | output | 1 | Data pin drive enable |
| irq_o | output | 1 | Completion interrupt request |

## Verification
The bench measures the exact cycle at which the flag rises for every internal divider. A divider that is off by one, or a counter that does not reset on start, shows up as a shifted flag cycle. It watches `sd_o` on every cycle, so output that changes on the rising edge or off an edge is caught. Each transfer uses a distinct pattern in each direction, which exposes a reversed bit order or a receive bit inserted at the wrong end. Writes to the data and mode registers land in the middle of transfers. A design that accepted them would end with a corrupted byte, a changed bit order or timing, or a switch to the external clock.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    CK_FAST = 2'b00,
    CK_MID  = 2'b01,
    CK_SLOW = 2'b10,
    CK_EXT  = 2'b11
  } ck_sel_e;

  // bit 7 down to bit 0
  typedef struct packed {
    logic    flag;
    logic    ie;
    logic    ck_oe;
    logic    d_oe;
    ck_sel_e sel;
    logic    lsb_first;
    logic    go;
  } mode_t;
endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen
  import ssp_pkg::*;
#(
  parameter int HALF_FAST   = 1,
  parameter int HALF_MID    = 4,
  parameter int HALF_SLOW   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    busy_i,
  input  logic    begin_i,
  input  ck_sel_e sel_i,
  input  logic    sck_i,
  output logic    fall_o,
  output logic    rise_o,
  output logic    sck_o
);
  localparam int HALF_MAX = (HALF_SLOW > HALF_MID) ?
                            ((HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST) :
                            ((HALF_MID > HALF_FAST) ? HALF_MID : HALF_FAST);
  localparam int CNT_W = $clog2(HALF_MAX + 1);

  logic [CNT_W-1:0]     cnt_q, half_m1;
  logic                 sck_q, ext, tick;
  logic [SYNC_STAGES:0] sync_q;
  logic                 s_old, s_new;

  always_comb begin
    case (sel_i)
      CK_FAST: half_m1 = CNT_W'(HALF_FAST - 1);
      CK_MID:  half_m1 = CNT_W'(HALF_MID - 1);
      default: half_m1 = CNT_W'(HALF_SLOW - 1);
    endcase
  end

  assign ext  = (sel_i == CK_EXT);
  assign tick = busy_i && !ext && (cnt_q == half_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (begin_i) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (busy_i && !ext) begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick) sck_q <= ~sck_q;
    end
  end

  // synchronizer plus one history flop for edge detection
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], sck_i};
  end

  assign s_old = sync_q[SYNC_STAGES];
  assign s_new = sync_q[SYNC_STAGES-1];

  assign fall_o = ext ? (busy_i && s_old && !s_new) : (tick && sck_q);
  assign rise_o = ext ? (busy_i && !s_old && s_new) : (tick && !sck_q);
  assign sck_o  = sck_q;

  p_sck_idle_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !begin_i) |=> sck_o);

  p_edges_exclusive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fall_o && rise_o));
endmodule

// File: rtl/ssp_shift.sv
module ssp_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              begin_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              lsb_first_i,
  input  logic              fall_i,
  input  logic              rise_i,
  input  logic              sd_i,
  output logic              sd_o,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o
);
  localparam int BC_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sr_q;
  logic [BC_W-1:0]   bcnt_q;
  logic              sd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      bcnt_q <= '0;
      sd_q   <= 1'b1;
    end else begin
      if (load_i) sr_q <= load_data_i;
      if (begin_i) bcnt_q <= '0;
      if (busy_i && fall_i) sd_q <= lsb_first_i ? sr_q[0] : sr_q[DATA_W-1];
      if (busy_i && rise_i) begin
        sr_q   <= lsb_first_i ? {sd_i, sr_q[DATA_W-1:1]} : {sr_q[DATA_W-2:0], sd_i};
        bcnt_q <= bcnt_q + 1'b1;
      end
    end
  end

  assign done_o = busy_i && rise_i && (bcnt_q == BC_W'(DATA_W - 1));
  assign sd_o   = sd_q;
  assign data_o = sr_q;

  p_dout_on_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> $stable(sd_o));
endmodule

// File: rtl/ser_shift_port.sv
module ser_shift_port
  import ssp_pkg::*;
#(
  parameter int HALF_FAST   = 1,
  parameter int HALF_MID    = 4,
  parameter int HALF_SLOW   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe_o,
  input  logic       sd_i,
  output logic       sd_o,
  output logic       sd_oe_o,
  output logic       irq_o
);
  mode_t      mode_q, wmode;
  logic [7:0] mode_bits, data;
  logic       fall, rise, done, begin_x, load;

  assign wmode   = mode_t'(wdata_i);
  assign begin_x = wr_i && !addr_i && !mode_q.go && wmode.go;
  assign load    = wr_i && addr_i && !mode_q.go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
    end else begin
      if (wr_i && !addr_i) begin
        mode_q.ie    <= wmode.ie;
        mode_q.ck_oe <= wmode.ck_oe;
        mode_q.d_oe  <= wmode.d_oe;
        mode_q.flag  <= mode_q.flag & wmode.flag;
        if (!mode_q.go) begin
          mode_q.sel       <= wmode.sel;
          mode_q.lsb_first <= wmode.lsb_first;
          mode_q.go        <= wmode.go;
        end
      end
      if (done) begin
        mode_q.go   <= 1'b0;
        mode_q.flag <= 1'b1;
      end
    end
  end

  ssp_clkgen #(
    .HALF_FAST  (HALF_FAST),
    .HALF_MID   (HALF_MID),
    .HALF_SLOW  (HALF_SLOW),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_i (mode_q.go),
    .begin_i(begin_x),
    .sel_i  (mode_q.sel),
    .sck_i  (sck_i),
    .fall_o (fall),
    .rise_o (rise),
    .sck_o  (sck_o)
  );

  ssp_shift #(.DATA_W(8)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .busy_i     (mode_q.go),
    .begin_i    (begin_x),
    .load_i     (load),
    .load_data_i(wdata_i),
    .lsb_first_i(mode_q.lsb_first),
    .fall_i     (fall),
    .rise_i     (rise),
    .sd_i       (sd_i),
    .sd_o       (sd_o),
    .data_o     (data),
    .done_o     (done)
  );

  assign mode_bits = mode_q;
  assign rdata_o   = addr_i ? data : mode_bits;
  assign irq_o     = mode_q.flag && mode_q.ie;
  assign sck_oe_o  = mode_q.ck_oe;
  assign sd_oe_o   = mode_q.d_oe;

  p_done_sets_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> (mode_q.flag && !mode_q.go));

  p_data_held_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.go && !rise) |=> $stable(data));

  p_order_held_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.go && !done) |=> (mode_q.go && $stable(mode_q.sel) && $stable(mode_q.lsb_first)));
endmodule

// File: tb/ser_shift_port_bench.sv
`timescale 1ns/1ps
module ser_shift_port_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic       addr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       sck_i = 1'b1;
  logic       sck_o, sck_oe_o, sd_o, sd_oe_o, irq_o;
  logic       sd_i = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  ser_shift_port u_ser_shift_port (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .sck_i(sck_i), .sck_o(sck_o),
    .sck_oe_o(sck_oe_o), .sd_i(sd_i), .sd_o(sd_o), .sd_oe_o(sd_oe_o),
    .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int half_of(input logic [1:0] code);
    return (code == 2'b00) ? 1 : (code == 2'b01) ? 4 : 16;
  endfunction

  // bit k in time order for a byte under the given order
  function automatic logic bit_at(input logic [7:0] v, input logic ord, input int k);
    return ord ? v[k] : v[7-k];
  endfunction

  task automatic wreg(input logic a, input logic [7:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0; addr_i = 1'b0;
    #1;
  endtask

  task automatic rreg(input logic a, output logic [7:0] d);
    addr_i = a; #1; d = rdata_o; addr_i = 1'b0; #1;
  endtask

  task automatic run_int(input logic [1:0] code, input logic ord, input logic [7:0] tx,
                         input logic [7:0] rv, input logic ie, input int poke);
    int h = half_of(code);
    logic [7:0] got = '0;
    logic [7:0] rd;
    int nf = 0, nr = 0, flag_at = -1;
    logic psck = 1'b1, psd;
    bit bad3 = 0, badoe = 0;
    wreg(1'b1, tx);
    wreg(1'b0, {1'b0, ie, 1'b1, 1'b1, code, ord, 1'b1});
    psd = sd_o;
    for (int n = 1; n <= 16 * h + 3; n++) begin
      if (poke == 1 && n == 2) begin
        wr_i = 1'b1; addr_i = 1'b1; wdata_i = ~tx;
      end else if (poke == 2 && n == 2) begin
        wr_i = 1'b1; addr_i = 1'b0; wdata_i = {1'b0, ie, 1'b1, 1'b1, ~code, ~ord, 1'b0};
      end
      @(negedge clk);
      wr_i = 1'b0; addr_i = 1'b0;
      #1;
      if (psck && !sck_o) begin
        sd_i = bit_at(rv, ord, nf);
        nf++;
      end
      if (!psck && sck_o) begin
        if (nr < 8) got[ord ? nr : 7 - nr] = sd_o;
        nr++;
      end
      if (sd_o !== psd && !(psck && !sck_o)) bad3 = 1;
      if (rdata_o[7] && flag_at < 0) flag_at = n;
      if (sck_oe_o !== 1'b1 || sd_oe_o !== 1'b1) badoe = 1;
      psck = sck_o; psd = sd_o;
    end
    chk(flag_at == 16 * h, "R4 flag cycle", flag_at, 16 * h);
    chk(nf == 8 && nr == 8, "R4 edge count", nf * 16 + nr, 8 * 16 + 8);
    chk(sck_o == 1'b1, "R4 clock idles high", sck_o, 1);
    chk(!bad3, "R3 sd_o moved off a falling edge", bad3, 0);
    chk(got == tx, "R6 transmitted byte/order (R10 if poked)", got, tx);
    rreg(1'b1, rd);
    chk(rd == rv, "R7 received byte (R9 if poked)", rd, rv);
    rreg(1'b0, rd);
    chk(rd[0] == 1'b0 && rd[7] == 1'b1, "R7 start cleared, flag set", rd, 8'h80);
    chk(irq_o == ie, "R8 irq follows enable", irq_o, ie);
    chk(!badoe, "R11 pin enables during transfer", badoe, 0);
  endtask

  task automatic run_ext(input logic ord, input logic [7:0] tx, input logic [7:0] rv,
                         input logic ie);
    logic [7:0] got = '0;
    logic [7:0] rd;
    bit sck_moved = 0;
    wreg(1'b1, tx);
    wreg(1'b0, {1'b0, ie, 1'b0, 1'b1, 2'b11, ord, 1'b1});
    for (int k = 0; k < 8; k++) begin
      sck_i = 1'b0; sd_i = bit_at(rv, ord, k);
      repeat (5) begin @(negedge clk); if (sck_o !== 1'b1) sck_moved = 1; end
      got[ord ? k : 7 - k] = sd_o;
      if (k == 7) begin
        #1; chk(rdata_o[7] == 1'b0, "R5 flag not before last rising edge", rdata_o[7], 0);
      end
      sck_i = 1'b1;
      repeat (5) begin @(negedge clk); if (sck_o !== 1'b1) sck_moved = 1; end
    end
    #1;
    chk(!sck_moved, "R5 sck_o stays high on external clock", sck_moved, 0);
    chk(got == tx, "R5 R6 transmitted byte on external clock", got, tx);
    rreg(1'b1, rd);
    chk(rd == rv, "R5 R7 received byte on external clock", rd, rv);
    rreg(1'b0, rd);
    chk(rd[7] && !rd[0], "R7 flag/start after external transfer", rd, 8'h80);
    chk(sck_oe_o == 1'b0 && sd_oe_o == 1'b1, "R11 pin enables external", {sck_oe_o, sd_oe_o}, 2'b01);
    chk(irq_o == ie, "R8 irq after external transfer", irq_o, ie);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #1;

    // R1 reset state
    rreg(1'b0, rd);
    chk(rd == 8'h00, "R1 mode after reset", rd, 0);
    rreg(1'b1, rd);
    chk(rd == 8'h00, "R1 data after reset", rd, 0);
    chk(sck_o && sd_o && !irq_o, "R1 pins after reset", {sck_o, sd_o, irq_o}, 3'b110);

    // R2 R11 field readback
    wreg(1'b0, 8'h76);
    rreg(1'b0, rd);
    chk(rd == 8'h76, "R2 mode readback", rd, 8'h76);
    chk(sck_oe_o && sd_oe_o, "R11 enables set", {sck_oe_o, sd_oe_o}, 2'b11);
    wreg(1'b0, 8'h8C);
    rreg(1'b0, rd);
    chk(rd == 8'h0C, "R2 R8 flag not settable by write", rd, 8'h0C);
    chk(!sck_oe_o && !sd_oe_o, "R11 enables clear", {sck_oe_o, sd_oe_o}, 2'b00);

    // R9 idle data load
    wreg(1'b1, 8'hA5);
    rreg(1'b1, rd);
    chk(rd == 8'hA5, "R9 idle data write loads", rd, 8'hA5);

    // directed transfers over every code and order
    run_int(2'b00, 1'b0, 8'hB4, 8'h3C, 1'b1, 0);
    // R8 flag write semantics
    wreg(1'b0, 8'hF0);
    chk(irq_o == 1'b1, "R8 writing 1 keeps flag", irq_o, 1);
    wreg(1'b0, 8'h70);
    rreg(1'b0, rd);
    chk(rd[7] == 1'b0 && irq_o == 1'b0, "R8 writing 0 clears flag", {rd[7], irq_o}, 0);

    run_int(2'b01, 1'b1, 8'h1E, 8'hC3, 1'b0, 0);
    run_int(2'b10, 1'b0, 8'h81, 8'h7E, 1'b1, 0);
    run_int(2'b01, 1'b0, 8'h5A, 8'h96, 1'b1, 1);
    run_int(2'b00, 1'b1, 8'hE1, 8'h2D, 1'b0, 2);
    run_ext(1'b0, 8'hC5, 8'h39, 1'b1);
    run_ext(1'b1, 8'h0F, 8'hF1, 1'b0);

    // random mix
    for (int i = 0; i < 14; i++) begin
      logic [1:0] code = 2'($urandom % 3);
      run_int(code, 1'($urandom), 8'($urandom), 8'($urandom), 1'($urandom), int'($urandom % 3));
    end
    for (int i = 0; i < 6; i++) begin
      run_ext(1'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule